// File: doc/BRIEF.md
# Product-to-Accumulator Transfer Unit

This unit sits next to the multiplier of a fixed-point signal processor. It moves the 40-bit product value into one of two 40-bit accumulators, and it can negate that value, round it, or add it to another value on the way. It also works out the arithmetic status flags for the value it produces. Each cycle it takes the upper opcode byte of an instruction, the current product, both accumulators and one 32-bit secondary register. One cycle later it presents the accumulator write data, the destination select, a write enable and the new flags.

Some of these transfers run in the same step as a new multiply. The product input must then carry the value from before that multiply. This unit uses only that old product, and the multiplier and register file take care of storing the new one. In the rounding variants the low 16 bits are cleared by rounding to nearest with ties to even, not by truncation. Opcodes that are not transfers are ignored: they produce no write and the flags keep their values.

Top module: `prod_xfer_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the unit clears out_valid_o, acc_we_o, acc_dst_o, acc_data_o and every flag output.
- R2: Results appear exactly one cycle after a recognised opcode is presented with in_valid_i high. With in_valid_i low, out_valid_o is low in the next cycle. acc_dst_o equals opcode bit 0, which is instruction bit 8 (0 selects acc0, 1 selects acc1). acc_we_o is never high without out_valid_o.
- R3: Opcode 0110_111d (move) writes the product unchanged to accumulator d. Carry and overflow are 0.
- R4: Opcode 0111_111d (move negated) writes the two's complement of the product modulo 2^40. Carry and overflow are 0.
- R5: Opcode 1111_111d (move rounded) writes the product rounded at bit 16. The rule: add 0x8000 and clear bits 15:0, except that when bits 15:0 equal 0x8000 and bit 16 is 0, only the low bits are cleared. The written value has bits 15:0 equal to zero.
- R6: Opcode 1111_10sd (add secondary, rounded) writes round(product) plus the sign-extended secondary value with its bits 15:0 masked to zero. Carry is 1 exactly when the unrounded product, read as unsigned, is greater than the 40-bit result. Overflow is always 0.
- R7: Fused add opcodes 1001_s10r and 110s_t10r write acc[r] + product, modulo 2^40. Carry is the carry out of bit 39. Overflow is set when both operands have the same sign bit and the result's sign bit differs from it.
- R8: Fused move opcodes 1001_s11r and 110s_t11r write the product unchanged. Fused move-rounded opcodes 1001_s01r and 110s_t01r write the product rounded as in R5. Carry and overflow are 0.
- R9: Opcode 1000_0101 (test product) updates the flags from the product, with carry and overflow 0. It raises out_valid_o but keeps acc_we_o low, and acc_data_o carries the product.
- R10: The flags are defined on the 40-bit result: zero is result == 0; sign is bit 39; above32 is set when bits 39:31 are not all equal; t2eq is set when bits 31 and 30 are equal.
- R11: Any other opcode, or a cycle with in_valid_i low, gives out_valid_o = 0 and acc_we_o = 0 in the next cycle, and every flag output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | An opcode is presented this cycle |
| opc_i | input | 8 | Upper opcode byte (instruction bits 15:8) |
| prod_i | input | 40 | Product value from before any multiply in this step |
| acc0_i | input | 40 | Current value of accumulator 0 |
| acc1_i | input | 40 | Current value of accumulator 1 |
| sec_i | input | 32 | Selected secondary register, signed |
| out_valid_o | output | 1 | A recognised transfer or test completed |
| acc_we_o | output | 1 | Accumulator write enable |
| acc_dst_o | output | 1 | Destination accumulator index |
| acc_data_o | output | 40 | Accumulator write data (the result) |
| flag_zero_o | output | 1 | Result is zero |
| flag_sign_o | output | 1 | Result bit 39 |
| flag_above_o | output | 1 | Result does not fit in 32 signed bits |
| flag_t2eq_o | output | 1 | Result bits 31 and 30 are equal |
| flag_carry_o | output | 1 | Carry as defined per operation |
| flag_ovf_o | output | 1 | Signed overflow of the fused add |

## Verification
The cases hardest to reach are the rounding ties and the carry rule of the add-secondary operation. The tie only shows when bits 15:0 are exactly 0x8000, and carry only rises when the rounded sum wraps below the unsigned old product. The stimulus therefore drives products whose low half sits at, just below and just above the tie, with bit 16 both set and clear. It pairs a product of -65536 with a secondary value of +65536 so that the sum wraps to zero. Ignored opcodes are interleaved between transfers that leave non-zero flags, so that any flag corruption is visible at the ports.

// File: rtl/prod_xfer_pkg.sv
// Package: shared operation kinds and the flag bundle for the transfer unit.
// Assumes: flags are produced together and registered as one group.
package prod_xfer_pkg;

    typedef enum logic [2:0] {
        XK_NONE   = 3'd0,
        XK_MOVE   = 3'd1,
        XK_NEG    = 3'd2,
        XK_RND    = 3'd3,
        XK_ADDSEC = 3'd4,
        XK_ADDACC = 3'd5,
        XK_TEST   = 3'd6
    } xfer_kind_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic above;
        logic t2eq;
        logic carry;
        logic ovf;
    } xfer_flags_t;

endpackage

// File: rtl/prod_xfer_decode.sv
// Module: opcode decoder. Maps the upper opcode byte to a transfer kind and
// the destination select (bit 0). Assumes the byte is instruction bits 15:8.
module prod_xfer_decode
    import prod_xfer_pkg::*;
(
    input  logic [7:0]  opc,
    output xfer_kind_e  kind,
    output logic        dst
);

    // Purpose: classify the opcode; anything unlisted maps to XK_NONE.
    always_comb begin
        kind = XK_NONE;
        dst  = opc[0];
        if (opc[7:1] == 7'b0110111) begin
            kind = XK_MOVE;
        end else if (opc[7:1] == 7'b0111111) begin
            kind = XK_NEG;
        end else if (opc[7:1] == 7'b1111111) begin
            kind = XK_RND;
        end else if (opc[7:2] == 6'b111110) begin
            kind = XK_ADDSEC;
        end else if (opc == 8'b1000_0101) begin
            kind = XK_TEST;
        end else if ((opc[7:4] == 4'b1001) || (opc[7:5] == 3'b110)) begin
            case (opc[2:1])
                2'b10:   kind = XK_ADDACC;
                2'b11:   kind = XK_MOVE;
                2'b01:   kind = XK_RND;
                default: kind = XK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/prod_xfer_round.sv
// Module: round-to-nearest-even at bit CUT, clearing bits CUT-1:0.
// Assumes the value wraps modulo 2^W when rounding up at the top.
module prod_xfer_round #(
    parameter int W   = 40,
    parameter int CUT = 16
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] rnd
);

    localparam logic [W-1:0] HALF_M1 = {{(W-CUT+1){1'b0}}, {(CUT-1){1'b1}}};

    logic [W-1:0] biased;

    // Purpose: bias by half-minus-one plus the keep-LSB, then drop low bits.
    always_comb begin
        biased = val + HALF_M1 + {{(W-1){1'b0}}, val[CUT]};
        rnd    = {biased[W-1:CUT], {CUT{1'b0}}};
    end

endmodule

// File: rtl/prod_xfer_flags.sv
// Module: status flag generator from a W-bit result plus carry/overflow.
// Assumes MID is the width of the narrow signed range tested by 'above'.
module prod_xfer_flags
    import prod_xfer_pkg::*;
#(
    parameter int W   = 40,
    parameter int MID = 32
) (
    input  logic [W-1:0] res,
    input  logic         carry,
    input  logic         ovf,
    output xfer_flags_t  fl
);

    localparam int TOP_N = W - MID + 1;

    logic [TOP_N-1:0] top_bits;

    // Purpose: derive each flag from the result bits.
    always_comb begin
        top_bits = res[W-1:MID-1];
        fl.zero  = (res == '0);
        fl.sign  = res[W-1];
        fl.above = !((top_bits == '0) || (top_bits == '1));
        fl.t2eq  = (res[MID-1] == res[MID-2]);
        fl.carry = carry;
        fl.ovf   = ovf;
    end

endmodule

// File: rtl/prod_xfer_unit.sv
// Module: product-to-accumulator transfer unit (top). Computes the transfer
// result for one opcode and registers data, destination and flags.
// Assumes prod_i is the product from before any multiply issued this step.
module prod_xfer_unit
    import prod_xfer_pkg::*;
#(
    parameter int ACC_W = 40,
    parameter int SEC_W = 32,
    parameter int CUT_W = 16,
    parameter int MID_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [7:0]       opc_i,
    input  logic [ACC_W-1:0] prod_i,
    input  logic [ACC_W-1:0] acc0_i,
    input  logic [ACC_W-1:0] acc1_i,
    input  logic [SEC_W-1:0] sec_i,
    output logic             out_valid_o,
    output logic             acc_we_o,
    output logic             acc_dst_o,
    output logic [ACC_W-1:0] acc_data_o,
    output logic             flag_zero_o,
    output logic             flag_sign_o,
    output logic             flag_above_o,
    output logic             flag_t2eq_o,
    output logic             flag_carry_o,
    output logic             flag_ovf_o
);

    localparam int               EXT_W    = ACC_W - SEC_W;
    localparam logic [ACC_W-1:0] LOW_MASK = {{(ACC_W-CUT_W){1'b0}}, {CUT_W{1'b1}}};

    xfer_kind_e       kind;
    logic             dst;
    logic [ACC_W-1:0] acc_sel;
    logic [ACC_W-1:0] prod_rnd;
    logic [ACC_W-1:0] sec_ext;
    logic [ACC_W:0]   sum_acc;
    logic [ACC_W-1:0] res;
    logic             res_c;
    logic             res_v;
    logic             recog;
    logic             writes;
    xfer_flags_t      fl_next;
    xfer_flags_t      fl_q;

    prod_xfer_decode u_dec (
        .opc  (opc_i),
        .kind (kind),
        .dst  (dst)
    );

    prod_xfer_round #(.W(ACC_W), .CUT(CUT_W)) u_rnd (
        .val (prod_i),
        .rnd (prod_rnd)
    );

    // Purpose: pick operands for the add forms.
    always_comb begin
        acc_sel = dst ? acc1_i : acc0_i;
        sec_ext = {{EXT_W{sec_i[SEC_W-1]}}, sec_i} & ~LOW_MASK;
        sum_acc = {1'b0, acc_sel} + {1'b0, prod_i};
    end

    // Purpose: select the result, carry and overflow for the decoded kind.
    always_comb begin
        res   = prod_i;
        res_c = 1'b0;
        res_v = 1'b0;
        case (kind)
            XK_NEG:    res = -prod_i;
            XK_RND:    res = prod_rnd;
            XK_ADDSEC: begin
                res   = prod_rnd + sec_ext;
                res_c = (prod_i > res);
            end
            XK_ADDACC: begin
                res   = sum_acc[ACC_W-1:0];
                res_c = sum_acc[ACC_W];
                res_v = (acc_sel[ACC_W-1] == prod_i[ACC_W-1]) &&
                        (res[ACC_W-1] != prod_i[ACC_W-1]);
            end
            default:   res = prod_i;
        endcase
        recog  = in_valid_i && (kind != XK_NONE);
        writes = recog && (kind != XK_TEST);
    end

    prod_xfer_flags #(.W(ACC_W), .MID(MID_W)) u_flg (
        .res   (res),
        .carry (res_c),
        .ovf   (res_v),
        .fl    (fl_next)
    );

    // Purpose: register the handshake and the write enable every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            acc_we_o    <= 1'b0;
        end else begin
            out_valid_o <= recog;
            acc_we_o    <= writes;
        end
    end

    // Purpose: capture data, destination and flags only on recognised ops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_dst_o  <= 1'b0;
            acc_data_o <= '0;
            fl_q       <= '0;
        end else if (recog) begin
            acc_dst_o  <= dst;
            acc_data_o <= res;
            fl_q       <= fl_next;
        end
    end

    assign flag_zero_o  = fl_q.zero;
    assign flag_sign_o  = fl_q.sign;
    assign flag_above_o = fl_q.above;
    assign flag_t2eq_o  = fl_q.t2eq;
    assign flag_carry_o = fl_q.carry;
    assign flag_ovf_o   = fl_q.ovf;

endmodule

// File: rtl/prod_xfer_unit_chk.sv
// Module: protocol and result checker bound to prod_xfer_unit.
// Assumes the reset is synchronous and held low for at least one edge.
module prod_xfer_unit_chk #(
    parameter int ACC_W = 40,
    parameter int CUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid_i,
    input logic [7:0]       opc_i,
    input logic [ACC_W-1:0] prod_i,
    input logic             out_valid_o,
    input logic             acc_we_o,
    input logic [ACC_W-1:0] acc_data_o,
    input logic             flag_zero_o,
    input logic             flag_sign_o,
    input logic             flag_above_o,
    input logic             flag_t2eq_o,
    input logic             flag_carry_o,
    input logic             flag_ovf_o
);

    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o) else $error("idle gave output"); // R2

    AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we_o |-> out_valid_o) else $error("write without valid"); // R2

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opc_i == 8'b1000_0101) |=> (out_valid_o && !acc_we_o))
        else $error("test product wrote"); // R9

    AST_NEG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opc_i[7:1] == 7'b0111111) |=> (acc_data_o == -$past(prod_i)))
        else $error("negation wrong"); // R4

    AST_RND_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opc_i[7:1] == 7'b1111111) |=> (acc_data_o[CUT_W-1:0] == '0))
        else $error("rounded low bits not clear"); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opc_i[7:2] == 6'b111110) |=> !flag_ovf_o)
        else $error("add-secondary overflow set"); // R6

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (flag_zero_o == (acc_data_o == '0)))
        else $error("zero flag mismatch"); // R10

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(flag_zero_o) && $stable(flag_sign_o) &&
                         $stable(flag_above_o) && $stable(flag_t2eq_o) &&
                         $stable(flag_carry_o) && $stable(flag_ovf_o)))
        else $error("flags changed while idle"); // R11

endmodule

bind prod_xfer_unit prod_xfer_unit_chk #(.ACC_W(ACC_W), .CUT_W(CUT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid_i   (in_valid_i),
    .opc_i        (opc_i),
    .prod_i       (prod_i),
    .out_valid_o  (out_valid_o),
    .acc_we_o     (acc_we_o),
    .acc_data_o   (acc_data_o),
    .flag_zero_o  (flag_zero_o),
    .flag_sign_o  (flag_sign_o),
    .flag_above_o (flag_above_o),
    .flag_t2eq_o  (flag_t2eq_o),
    .flag_carry_o (flag_carry_o),
    .flag_ovf_o   (flag_ovf_o)
);

// File: tb/prod_xfer_unit_tb_top.sv
// Bench: scoreboard for prod_xfer_unit. The driver pushes expected items,
// and the monitor pops and compares them one cycle after each drive.
module prod_xfer_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic        vld;
        logic        we;
        logic        dst;
        logic [39:0] data;
        logic [5:0]  fl;   // zero, sign, above, t2eq, carry, ovf
        int          cyc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  opc_i = '0;
    logic [39:0] prod_i = '0;
    logic [39:0] acc0_i = '0;
    logic [39:0] acc1_i = '0;
    logic [31:0] sec_i = '0;
    logic        out_valid_o, acc_we_o, acc_dst_o;
    logic [39:0] acc_data_o;
    logic        flag_zero_o, flag_sign_o, flag_above_o;
    logic        flag_t2eq_o, flag_carry_o, flag_ovf_o;

    int   checks = 0;
    int   fails = 0;
    int   cyc_cnt = 0;
    exp_t scq[$];
    logic [5:0] model_fl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    prod_xfer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .opc_i(opc_i),
        .prod_i(prod_i), .acc0_i(acc0_i), .acc1_i(acc1_i), .sec_i(sec_i),
        .out_valid_o(out_valid_o), .acc_we_o(acc_we_o), .acc_dst_o(acc_dst_o),
        .acc_data_o(acc_data_o), .flag_zero_o(flag_zero_o),
        .flag_sign_o(flag_sign_o), .flag_above_o(flag_above_o),
        .flag_t2eq_o(flag_t2eq_o), .flag_carry_o(flag_carry_o),
        .flag_ovf_o(flag_ovf_o)
    );

    function automatic logic [39:0] m_round(input logic [39:0] p);
        logic [39:0] t;
        t = {p[39:16], 16'h0000};
        if (p[15:0] > 16'h8000 || (p[15:0] == 16'h8000 && p[16]))
            t = t + 40'h1_0000;
        return t;
    endfunction

    function automatic logic [5:0] m_flags(input logic [39:0] r, input logic c, input logic v);
        logic above;
        above = !(r[39:31] == 9'h000 || r[39:31] == 9'h1FF);
        return {r == 40'h0, r[39], above, r[31] == r[30], c, v};
    endfunction

    task automatic check(input string tag, input string what, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: present one opcode and push the expected result.
    task automatic send(input string tag, input logic [7:0] op, input logic [39:0] p,
                        input logic [39:0] a0, input logic [39:0] a1, input logic [31:0] s);
        exp_t e;
        logic [39:0] r, acc, sx;
        logic [40:0] w;
        logic c, v;
        @(negedge clk);
        in_valid_i = 1'b1; opc_i = op; prod_i = p; acc0_i = a0; acc1_i = a1; sec_i = s;
        e.vld = 1'b1; e.we = 1'b1; e.dst = op[0]; c = 1'b0; v = 1'b0; r = p;
        casez (op)
            8'b0110111?: r = p;
            8'b0111111?: r = ~p + 40'd1;
            8'b1111111?: r = m_round(p);
            8'b111110??: begin
                sx = {{8{s[31]}}, s[31:16], 16'h0000};
                r  = m_round(p) + sx;
                c  = (p > r);
            end
            8'b10000101: e.we = 1'b0;
            8'b1001?10?, 8'b110??10?: begin
                acc = op[0] ? a1 : a0;
                w   = {1'b0, acc} + {1'b0, p};
                r   = w[39:0];
                c   = w[40];
                v   = (acc[39] == p[39]) && (r[39] != acc[39]);
            end
            8'b1001?11?, 8'b110??11?: r = p;
            8'b1001?01?, 8'b110??01?: r = m_round(p);
            default: begin e.vld = 1'b0; e.we = 1'b0; end
        endcase
        if (e.vld) model_fl = m_flags(r, c, v);
        e.data = r; e.fl = model_fl; e.cyc = cyc_cnt; e.tag = tag;
        scq.push_back(e);
    endtask

    // Driver: one idle cycle, flags must hold.
    task automatic idle(input logic [7:0] op);
        exp_t e;
        @(negedge clk);
        in_valid_i = 1'b0; opc_i = op;
        e.vld = 1'b0; e.we = 1'b0; e.dst = 1'b0; e.data = '0;
        e.fl = model_fl; e.cyc = cyc_cnt; e.tag = "R11";
        scq.push_back(e);
    endtask

    // Monitor: compare the oldest item one cycle after it was driven.
    always @(negedge clk) begin
        if (rst_n && scq.size() > 0 && scq[0].cyc < cyc_cnt) begin
            exp_t e;
            logic [5:0] got;
            e   = scq.pop_front();
            got = {flag_zero_o, flag_sign_o, flag_above_o, flag_t2eq_o, flag_carry_o, flag_ovf_o};
            check(e.tag, "valid (R2)", {39'd0, out_valid_o}, {39'd0, e.vld});
            check(e.tag, "we", {39'd0, acc_we_o}, {39'd0, e.we});
            check(e.tag, "flags (R10)", {34'd0, got}, {34'd0, e.fl});
            if (e.vld) check(e.tag, "data", acc_data_o, e.data);
            if (e.we) check(e.tag, "dst (R2)", {39'd0, acc_dst_o}, {39'd0, e.dst});
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "valid", {39'd0, out_valid_o}, 40'd0);
        check("R1", "we", {39'd0, acc_we_o}, 40'd0);
        check("R1", "data", acc_data_o, 40'd0);
        check("R1", "flags", {34'd0, flag_zero_o, flag_sign_o, flag_above_o,
                              flag_t2eq_o, flag_carry_o, flag_ovf_o}, 40'd0);
        rst_n = 1'b1;
        // R3 move, both destinations
        send("R3", 8'h6E, 40'h12_3456_789A, '0, '0, '0);
        send("R3", 8'h6F, 40'hFF_8000_0000, '0, '0, '0);
        // R4 negate
        send("R4", 8'h7E, 40'h00_0000_0001, '0, '0, '0);
        send("R4", 8'h7F, 40'h80_0000_0000, '0, '0, '0);
        // R5 rounding ties and neighbours
        send("R5", 8'hFE, 40'h00_0001_8000, '0, '0, '0);
        send("R5", 8'hFF, 40'h00_0002_8000, '0, '0, '0);
        send("R5", 8'hFE, 40'h00_0002_8001, '0, '0, '0);
        send("R5", 8'hFE, 40'h00_0002_7FFF, '0, '0, '0);
        send("R5", 8'hFF, 40'hFF_FFFF_8000, '0, '0, '0);
        // R6 add secondary, wrap to zero with carry, and negative secondary
        send("R6", 8'hF8, 40'hFF_FFFF_0000, '0, '0, 32'h0001_0000);
        send("R6", 8'hFB, 40'h00_0001_8000, '0, '0, 32'h8000_FFFF);
        send("R6", 8'hF9, 40'h00_1234_0000, '0, '0, 32'h0000_FFFF);
        // R7 fused add: overflow, carry, plain
        send("R7", 8'h94, 40'h00_0000_0001, 40'h7F_FFFF_FFFF, '0, '0);
        send("R7", 8'h95, 40'h00_0000_0002, '0, 40'hFF_FFFF_FFFF, '0);
        send("R7", 8'hC5, 40'h00_4000_0000, '0, 40'h00_0000_1000, '0);
        // R8 fused move and fused move-rounded
        send("R8", 8'h96, 40'h00_4000_0000, '0, '0, '0);
        send("R8", 8'hD3, 40'h00_0003_8000, '0, '0, '0);
        // R9 test product
        send("R9", 8'h85, 40'h00_0000_0000, '0, '0, '0);
        send("R9", 8'h85, 40'h00_8000_0000, '0, '0, '0);
        // R11 ignored opcodes and idle cycles, flags must hold
        send("R11", 8'h90, 40'h00_0000_0000, '0, '0, '0);
        send("R11", 8'hF2, 40'h00_0000_0000, '0, '0, '0);
        idle(8'h6E);
        send("R11", 8'h00, 40'h00_0000_0000, '0, '0, '0);
        // R2 back-to-back after idle
        send("R2", 8'hC7, 40'h00_0000_0005, '0, '0, '0);
        idle(8'h00);
        idle(8'h00);
        while (scq.size() > 0) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule